// File: doc/BRIEF.md
# Multi-Mode Transmit Byte Serializer

This block converts words from a wide, slow transmit interface into a narrower, faster stream for the rest of a transmit datapath. Two clocks are involved. A slow clock carries an input word and its valid flag. A fast clock runs at one, two or four times the slow rate, with rising edges aligned to the slow clock. Each slow period's word leaves as one, two or four slices on the fast side, so throughput is preserved.

The ratio comes from a static mode field. The input word width comes from a static width code. The width code also fixes the slice width, which is the word width divided by the ratio. Slices always leave least significant first. A slice sequence always restarts at slice 0 when a new word arrives, so the output stays aligned to word boundaries. Combinations of mode and width that the downstream path cannot accept raise a configuration error. While the error is raised, output valid stays low.

Top module: `bser_top`

## Requirements
- R1: While reset is low, out_vld and out_data are zero. After reset is released, the first output with out_vld high is slice 0 of the first valid word captured.
- R2: cfg_mode = 0 selects bypass. The fast clock equals the slow clock. A word captured at a slow edge appears on out_data, with out_vld high, after the next fast edge.
- R3: cfg_mode = 1 selects x2. The fast clock runs at twice the slow rate. Each word gives two slices of half its width, on two consecutive fast cycles: bits [w/2-1:0] first, then bits [w-1:w/2]. These are legal for every width when cfg_enc_used = 0.
- R4: cfg_mode = 2 selects x4. It is legal only with cfg_width = 2 (32 bits). Each word gives four 8-bit slices on four consecutive fast cycles, in the order [7:0], [15:8], [23:16], [31:24].
- R5: cfg_width selects the input width: 0 gives 16 bits, 1 gives 20, 2 gives 32, 3 gives 40. Input bits at or above the selected width are ignored. out_data bits at or above the slice width read zero.
- R6: When in_vld is low at a slow edge, out_vld is low and out_data is zero for every slice of that slow period.
- R7: All slices of one word share a single valid value. out_vld changes only on the first fast cycle of a word.
- R8: cfg_err is high for cfg_mode = 3, for x4 with any width other than 32, and for x2 with width 20 or 40 when cfg_enc_used = 1. While cfg_err is high, out_vld stays low and out_data stays zero.
- R9: Exactly ratio fast cycles separate consecutive word starts, where ratio is 1, 2 or 4 as set by the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Input-side clock |
| clk_fast | input | 1 | Output-side clock, an edge-aligned multiple (1, 2 or 4) of clk_slow |
| rst_n | input | 1 | Synchronous active-low reset for both domains |
| cfg_mode | input | 2 | Static ratio: 0 bypass, 1 x2, 2 x4, 3 reserved |
| cfg_width | input | 2 | Static input width code: 0=16, 1=20, 2=32, 3=40 |
| cfg_enc_used | input | 1 | Downstream 8b/10b encoding is in use |
| in_data | input | DATA_W | Input word, sampled on clk_slow |
| in_vld | input | 1 | Input word valid, sampled on clk_slow |
| out_data | output | DATA_W | Output slice, right-aligned, upper bits zero |
| out_vld | output | 1 | Output slice valid |
| cfg_err | output | 1 | Illegal mode/width/encoding combination |

## Verification
The bench goes after slice order, word alignment, masking and illegal configurations. If the halves or quarters were swapped, every multi-slice word would mismatch on its first fast cycle. If the slice counter were not restarted at each new word, the sequence would drift and show a shifted slice after a word boundary. The bench also drives junk above the selected width, and a design that did not mask it would leak those bits into the top slice. It mixes invalid words among valid ones, so a design that held valid across a gap, or left stale data on an idle slice, would be caught. Finally it drives valid traffic under each illegal configuration, and any out_vld pulse seen there reveals a missing error gate.

// File: rtl/bser_pkg.sv
`timescale 1ns/1ps
// bser_pkg: shared encodings for the transmit byte serializer.
// Assumes mode and width codes are static while out of reset.
package bser_pkg;

    typedef enum logic [1:0] {
        SER_BYPASS = 2'd0,
        SER_X2     = 2'd1,
        SER_X4     = 2'd2,
        SER_RSVD   = 2'd3
    } ser_mode_e;

    localparam int MAX_WORD_W = 40;

    // Width code to word width in bits.
    function automatic int word_width(input logic [1:0] code);
        case (code)
            2'd0:    return 16;
            2'd1:    return 20;
            2'd2:    return 32;
            default: return 40;
        endcase
    endfunction

endpackage

// File: rtl/bser_cfg_decode.sv
`timescale 1ns/1ps
// bser_cfg_decode: turns the static mode/width/encoding settings into a
// word width, a slice width, a ratio-minus-one and a legality flag.
// Assumes the inputs only change while the block is held in reset.
module bser_cfg_decode
    import bser_pkg::*;
#(
    parameter int WW = 6
) (
    input  logic [1:0]    cfg_mode,
    input  logic [1:0]    cfg_width,
    input  logic          cfg_enc_used,
    output logic [WW-1:0] word_w,
    output logic [WW-1:0] slice_w,
    output logic [1:0]    ratio_m1,
    output logic          cfg_err
);

    ser_mode_e mode;

    // Decode widths, ratio and legality from the configuration.
    always_comb begin
        mode    = ser_mode_e'(cfg_mode);
        word_w  = WW'(word_width(cfg_width));
        case (mode)
            SER_X2: begin
                ratio_m1 = 2'd1;
                slice_w  = word_w >> 1;
                cfg_err  = cfg_enc_used && cfg_width[0];
            end
            SER_X4: begin
                ratio_m1 = 2'd3;
                slice_w  = word_w >> 2;
                cfg_err  = (cfg_width != 2'd2);
            end
            SER_BYPASS: begin
                ratio_m1 = 2'd0;
                slice_w  = word_w;
                cfg_err  = 1'b0;
            end
            default: begin
                ratio_m1 = 2'd0;
                slice_w  = word_w;
                cfg_err  = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/bser_slow_capture.sv
`timescale 1ns/1ps
// bser_slow_capture: slow-domain capture register. It masks the input word
// to the configured width, holds it with its valid flag for one slow period,
// and flips a marker each slow period so the fast side can see word starts.
// Assumes clk_fast edges are aligned to clk_slow edges.
module bser_slow_capture #(
    parameter int DATA_W = 40,
    parameter int WW     = 6
) (
    input  logic              clk_slow,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_vld,
    input  logic [WW-1:0]     word_w,
    output logic [DATA_W-1:0] hold_word,
    output logic              hold_vld,
    output logic              hold_tog
);

    logic [DATA_W-1:0] width_mask;

    // Keep only the bits below the configured word width.
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            width_mask[i] = (i < int'(word_w));
        end
    end

    // Capture one word per slow period and flip the period marker.
    always_ff @(posedge clk_slow) begin
        if (!rst_n) begin
            hold_word <= '0;
            hold_vld  <= 1'b0;
            hold_tog  <= 1'b0;
        end else begin
            hold_word <= in_data & width_mask;
            hold_vld  <= in_vld;
            hold_tog  <= ~hold_tog;
        end
    end

endmodule

// File: rtl/bser_slice_seq.sv
`timescale 1ns/1ps
// bser_slice_seq: fast-domain sequencer. It detects each word start from the
// slow-side marker, restarts the slice index at zero, and registers one
// right-aligned slice per fast cycle, least significant first.
// Assumes the held word is stable for a whole slow period.
module bser_slice_seq #(
    parameter int DATA_W = 40,
    parameter int WW     = 6
) (
    input  logic              clk_fast,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] hold_word,
    input  logic              hold_vld,
    input  logic              hold_tog,
    input  logic              cfg_err,
    input  logic [1:0]        ratio_m1,
    input  logic [WW-1:0]     slice_w,
    output logic [DATA_W-1:0] out_data,
    output logic              out_vld
);

    localparam int SHW = WW + 2;

    logic              tog_seen;
    logic              new_word;
    logic [1:0]        idx;
    logic [1:0]        sel;
    logic [SHW-1:0]    shamt;
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] slice_mask;
    logic              emit;

    assign new_word = hold_tog ^ tog_seen;
    assign sel      = new_word ? 2'd0 : idx;
    assign emit     = hold_vld && !cfg_err;

    // Select the current slice and right-align it.
    always_comb begin
        shamt   = {{WW{1'b0}}, sel} * {2'b00, slice_w};
        shifted = hold_word >> shamt;
        for (int i = 0; i < DATA_W; i++) begin
            slice_mask[i] = (i < int'(slice_w));
        end
    end

    // Track word starts, step the slice index and register the output.
    always_ff @(posedge clk_fast) begin
        if (!rst_n) begin
            tog_seen <= 1'b0;
            idx      <= 2'd0;
            out_vld  <= 1'b0;
            out_data <= '0;
        end else begin
            tog_seen <= hold_tog;
            idx      <= new_word ? 2'd1 : idx + 2'd1;
            out_vld  <= emit;
            out_data <= emit ? (shifted & slice_mask) : '0;
        end
    end

    // Checker state: fast cycles since the last word start.
    logic [2:0] gap;
    logic       seen_start;

    // Count the spacing between word starts for the ratio check.
    always_ff @(posedge clk_fast) begin
        if (!rst_n) begin
            gap        <= 3'd0;
            seen_start <= 1'b0;
        end else if (new_word) begin
            gap        <= 3'd0;
            seen_start <= 1'b1;
        end else if (gap != 3'd7) begin
            gap <= gap + 3'd1;
        end
    end

    AST_WORD_SPACING: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (new_word && seen_start) |-> (gap == {1'b0, ratio_m1})); // R9

    AST_VLD_WORD_ALIGNED: assert property (@(posedge clk_fast) disable iff (!rst_n)
        !new_word |=> $stable(out_vld)); // R7

    AST_IDLE_ZERO: assert property (@(posedge clk_fast) disable iff (!rst_n)
        !out_vld |-> (out_data == '0)); // R6

endmodule

// File: rtl/bser_top.sv
`timescale 1ns/1ps
// bser_top: multi-mode transmit byte serializer (bypass, x2, x4).
// Input words arrive on clk_slow. Slices leave on clk_fast, least
// significant first. Assumes clk_fast runs at 1, 2 or 4 times clk_slow
// to match cfg_mode, with aligned rising edges, and that the configuration
// only changes under reset.
module bser_top #(
    parameter int DATA_W = 40
) (
    input  logic              clk_slow,
    input  logic              clk_fast,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic [1:0]        cfg_width,
    input  logic              cfg_enc_used,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_vld,
    output logic [DATA_W-1:0] out_data,
    output logic              out_vld,
    output logic              cfg_err
);

    localparam int WW = $clog2(DATA_W + 1);

    logic [WW-1:0]     word_w;
    logic [WW-1:0]     slice_w;
    logic [1:0]        ratio_m1;
    logic [DATA_W-1:0] hold_word;
    logic              hold_vld;
    logic              hold_tog;

    bser_cfg_decode #(.WW(WW)) cfg_i (
        .cfg_mode     (cfg_mode),
        .cfg_width    (cfg_width),
        .cfg_enc_used (cfg_enc_used),
        .word_w       (word_w),
        .slice_w      (slice_w),
        .ratio_m1     (ratio_m1),
        .cfg_err      (cfg_err)
    );

    bser_slow_capture #(.DATA_W(DATA_W), .WW(WW)) cap_i (
        .clk_slow  (clk_slow),
        .rst_n     (rst_n),
        .in_data   (in_data),
        .in_vld    (in_vld),
        .word_w    (word_w),
        .hold_word (hold_word),
        .hold_vld  (hold_vld),
        .hold_tog  (hold_tog)
    );

    bser_slice_seq #(.DATA_W(DATA_W), .WW(WW)) seq_i (
        .clk_fast  (clk_fast),
        .rst_n     (rst_n),
        .hold_word (hold_word),
        .hold_vld  (hold_vld),
        .hold_tog  (hold_tog),
        .cfg_err   (cfg_err),
        .ratio_m1  (ratio_m1),
        .slice_w   (slice_w),
        .out_data  (out_data),
        .out_vld   (out_vld)
    );

    AST_ERR_BLOCKS_VLD: assert property (@(posedge clk_fast) disable iff (!rst_n)
        cfg_err |-> !out_vld); // R8

endmodule

// File: tb/bser_top_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural queue model of the serializer, compared every fast cycle.
module bser_top_tb_top;

    localparam int DATA_W = 40;

    logic              clk_fast = 1'b0;
    logic              clk_slow = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        cfg_mode = 2'd0;
    logic [1:0]        cfg_width = 2'd0;
    logic              cfg_enc_used = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              in_vld = 1'b0;
    logic [DATA_W-1:0] out_data;
    logic              out_vld;
    logic              cfg_err;

    bser_top #(.DATA_W(DATA_W)) dut_i (
        .clk_slow     (clk_slow),
        .clk_fast     (clk_fast),
        .rst_n        (rst_n),
        .cfg_mode     (cfg_mode),
        .cfg_width    (cfg_width),
        .cfg_enc_used (cfg_enc_used),
        .in_data      (in_data),
        .in_vld       (in_vld),
        .out_data     (out_data),
        .out_vld      (out_vld),
        .cfg_err      (cfg_err)
    );

    int ratio = 1;
    int hcnt = 0;
    int n_checks = 0;
    int n_fail = 0;
    int fast_cycles = 0;
    bit done = 0;
    bit first_after_rst = 0;

    bit                qv[$];
    logic [DATA_W-1:0] qd[$];
    bit                exp_v = 0;
    logic [DATA_W-1:0] exp_d = '0;

    function automatic int wid(input logic [1:0] code);
        if (code == 2'd0) return 16;
        if (code == 2'd1) return 20;
        if (code == 2'd2) return 32;
        return 40;
    endfunction

    function automatic int rat(input logic [1:0] mode);
        if (mode == 2'd1) return 2;
        if (mode == 2'd2) return 4;
        return 1;
    endfunction

    function automatic bit legal(input logic [1:0] mode, input logic [1:0] code, input logic enc);
        if (mode == 2'd3) return 0;
        if (mode == 2'd2) return (code == 2'd2);
        if (mode == 2'd1) return !(enc && (code == 2'd1 || code == 2'd3));
        return 1;
    endfunction

    // Slice k of a word: bits [k*sw +: sw], sw = width / ratio.
    function automatic logic [DATA_W-1:0] slice_of(input logic [DATA_W-1:0] word,
                                                   input int w, input int r, input int k);
        logic [DATA_W-1:0] res;
        int sw;
        res = '0;
        sw  = w / r;
        for (int b = 0; b < sw; b++) res[b] = word[k * sw + b];
        return res;
    endfunction

    task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    // Model step at each fast rising edge: pop the slice due now, then
    // queue the slices of a word captured at a coinciding slow edge (R9).
    task automatic model_edge();
        bit ok;
        fast_cycles++;
        if (fast_cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", fast_cycles);
            finish_run();
        end
        if (qv.size() > 0) begin
            exp_v = qv.pop_front();
            exp_d = qd.pop_front();
        end else begin
            exp_v = 0;
            exp_d = '0;
        end
        if (hcnt == 0 && rst_n) begin
            ok = legal(cfg_mode, cfg_width, cfg_enc_used);
            for (int k = 0; k < ratio; k++) begin
                qv.push_back(in_vld && ok);
                qd.push_back((in_vld && ok) ? slice_of(in_data, wid(cfg_width), ratio, k) : '0);
            end
        end
    endtask

    // Compare at the fast falling edge, away from the active edge.
    task automatic model_compare();
        string tag;
        if (!rst_n) return;
        if (!legal(cfg_mode, cfg_width, cfg_enc_used)) tag = "R8";
        else if (!exp_v) tag = "R6";
        else if (first_after_rst) tag = "R1";
        else if (cfg_mode == 2'd0) tag = "R2/R5";
        else if (cfg_mode == 2'd1) tag = "R3/R5/R7";
        else tag = "R4/R7";
        chk(tag, {39'd0, out_vld}, {39'd0, exp_v});
        chk(tag, out_data, exp_d);
        if (exp_v) first_after_rst = 0;
    endtask

    // Clock generator (fast period 5 ns, 200 MHz) with the model driven from it.
    initial begin
        forever begin
            #2.5;
            hcnt     = (hcnt + 1) % (2 * ratio);
            clk_fast = (hcnt % 2 == 0);
            clk_slow = (hcnt < ratio);
            if (hcnt % 2 == 0) model_edge();
            else model_compare();
        end
    end

    task automatic run_cfg(input logic [1:0] mode, input logic [1:0] code,
                           input logic enc, input int nwords);
        @(negedge clk_fast);
        rst_n        = 0;
        in_vld       = 0;
        cfg_mode     = mode;
        cfg_width    = code;
        cfg_enc_used = enc;
        ratio        = rat(mode);
        hcnt         = 2 * ratio - 1;
        clk_slow     = 0;
        qv.delete();
        qd.delete();
        repeat (12) @(negedge clk_fast);
        chk("R1", {39'd0, out_vld}, '0);
        chk("R1", out_data, '0);
        chk("R8", {39'd0, cfg_err}, {39'd0, !legal(mode, code, enc)});
        first_after_rst = 1;
        rst_n = 1;
        for (int i = 0; i < nwords; i++) begin
            @(negedge clk_slow);
            if (i == 0) in_data = 40'hA5_4433_2211;   // junk above 32 bits for R5
            else if (i == 1) in_data = 40'hFF_FFFF_FFFF;
            else in_data = {$urandom, $urandom};
            in_vld = !((i % 5) == 3 || (i % 7) == 5);
        end
        @(negedge clk_slow);
        in_vld = 0;
        repeat (3) @(negedge clk_slow);
    endtask

    initial begin
        run_cfg(2'd0, 2'd0, 1'b0, 30);  // bypass 16
        run_cfg(2'd0, 2'd3, 1'b0, 30);  // bypass 40
        run_cfg(2'd1, 2'd0, 1'b0, 30);  // x2 16->8
        run_cfg(2'd1, 2'd1, 1'b0, 30);  // x2 20->10
        run_cfg(2'd1, 2'd2, 1'b0, 30);  // x2 32->16
        run_cfg(2'd1, 2'd3, 1'b0, 30);  // x2 40->20
        run_cfg(2'd1, 2'd2, 1'b1, 30);  // x2 32 with encoding
        run_cfg(2'd2, 2'd2, 1'b0, 30);  // x4 32->8
        run_cfg(2'd2, 2'd2, 1'b1, 30);  // x4 32->8 with encoding
        run_cfg(2'd2, 2'd0, 1'b0, 12);  // x4 16: illegal
        run_cfg(2'd1, 2'd1, 1'b1, 12);  // x2 20 with encoding: illegal
        run_cfg(2'd1, 2'd3, 1'b1, 12);  // x2 40 with encoding: illegal
        run_cfg(2'd3, 2'd2, 1'b0, 12);  // reserved mode: illegal
        finish_run();
    end

endmodule